// File: doc/BRIEF.md
# Serial Interrupt Status and Routing Controller

This block keeps the status register of a serial-interrupt host controller. A frame decoder upstream delivers one level per device interrupt. The block first registers those levels into an internal copy that is separate from the visible status register. Each status bit then latches high whenever its registered level is high, and it stays high until it is cleared.

Software clears status bits by writing ones to them. That clear is refused for any bit whose registered input level is still high, so an interrupt that is still pending cannot be lost. Two delivery modes exist, and a two-state machine holds the active mode:

- **MODE_AGGR** (after reset): every masked device status bit and every internal controller interrupt are ORed onto one host line.
- **MODE_STEER**: only internal controller interrupts drive the host line. Each device status bit is steered to one of four output lines by its own 2-bit routing field. An end-of-interrupt strobe naming a line clears, with no software write, the status bits routed to that line whose inputs are low.

The machine has two transitions. MODE_AGGR goes to MODE_STEER when `mode_steer_i` is sampled high. MODE_STEER goes back to MODE_AGGR when `mode_steer_i` is sampled low. Both states hold when the pin already matches.

Top module: `sirq_status_ctrl`

## Requirements
- R1: After reset, `status_o` is all zero, `host_irq_o` and `line_irq_o` are zero, and the mode is MODE_AGGR.
- R2: A device input that is high sets its status bit two clock edges later (one edge into the level copy, one into status). The bit stays set after the input falls, until it is cleared.
- R3: A cycle with `clr_valid_i` high clears, on the next edge, every bit set in `clr_bits_i` whose registered input level is low.
- R4: A clear request has no effect on a status bit whose registered input level is high.
- R5: In MODE_AGGR, `host_irq_o` is the OR of (`status_o` AND `irq_mask_i`) and of all `int_irq_i` bits, and `line_irq_o` is zero.
- R6: In MODE_STEER, `host_irq_o` is the OR of `int_irq_i` only. Bit k of `line_irq_o` is the OR of the status bits that are enabled in `irq_mask_i` and whose routing field `route_map_i[2*i+1:2*i]` equals k.
- R7: A zero mask bit stops that status bit from driving any output, but the status bit itself stays visible in `status_o`.
- R8: In MODE_STEER, an `eoi_valid_i` cycle with line number `eoi_line_i` clears, on the next edge, the status bits routed to that line whose registered inputs are low. Bits on other lines, and bits whose inputs are high, are kept.
- R9: In MODE_AGGR, `eoi_valid_i` has no effect on `status_o`.
- R10: A change of `mode_steer_i` takes effect on the outputs after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq_i | input | N_DEV | Device interrupt levels from the frame decoder |
| int_irq_i | input | N_INT | Internal controller interrupt sources |
| mode_steer_i | input | 1 | 0 selects single-line mode, 1 selects four-line steering |
| irq_mask_i | input | N_DEV | Per-device output enable |
| route_map_i | input | 2*N_DEV | Two-bit line number per device |
| clr_valid_i | input | 1 | Write-one-to-clear strobe |
| clr_bits_i | input | N_DEV | Bits to clear |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_line_i | input | 2 | Line number the end-of-interrupt targets |
| status_o | output | N_DEV | Latched status register |
| host_irq_o | output | 1 | Host-controller interrupt line |
| line_irq_o | output | 4 | Steered device interrupt lines |

## Verification
A lost level copy or a wrongly applied clear shows at `status_o` on the edge right after the clear or EOI strobe. A bit dropped while its input is high is the exact loss this block exists to prevent. A mode register stuck in the wrong state shows at once as the device interrupts appearing on the host line instead of the steered lines, or the reverse, within one cycle of the pin change. A wrong routing decode shows as the wrong bit of `line_irq_o`, and as an EOI that clears bits on the wrong line.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int unsigned N_LINE  = 4;
    localparam int unsigned LINE_W  = $clog2(N_LINE);

    typedef enum logic [0:0] {
        MODE_AGGR  = 1'b0,
        MODE_STEER = 1'b1
    } sirq_mode_e;
endpackage

// File: rtl/sirq_level_copy.sv
module sirq_level_copy #(
    parameter int unsigned N_DEV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] dev_irq_i,
    output logic [N_DEV-1:0] lvl_q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q_o <= '0;
        else        lvl_q_o <= dev_irq_i;
    end
endmodule

// File: rtl/sirq_status_bank.sv
module sirq_status_bank #(
    parameter int unsigned N_DEV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] lvl_i,
    input  logic             clr_valid_i,
    input  logic [N_DEV-1:0] clr_bits_i,
    input  logic [N_DEV-1:0] eoi_hit_i,
    output logic [N_DEV-1:0] status_o
);
    logic [N_DEV-1:0] status_q;

    for (genvar i = 0; i < N_DEV; i++) begin : g_bit
        logic drop_req;
        assign drop_req = (clr_valid_i && clr_bits_i[i]) || eoi_hit_i[i];
        always_ff @(posedge clk) begin
            if (!rst_n)         status_q[i] <= 1'b0;
            else if (lvl_i[i])  status_q[i] <= 1'b1;
            else if (drop_req)  status_q[i] <= 1'b0;
        end
    end

    assign status_o = status_q;

    // R4: a high level copy always leaves its status bit set on the next edge
    assert_clear_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(lvl_i)) == $past(lvl_i)));

    // R2: with no clear and no EOI, no set bit ever falls
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_valid_i && (eoi_hit_i == '0)) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/sirq_line_router.sv
module sirq_line_router
    import sirq_pkg::*;
#(
    parameter int unsigned N_DEV = 8,
    parameter int unsigned N_INT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    steer_en_i,
    input  logic [N_DEV-1:0]        status_i,
    input  logic [N_DEV-1:0]        mask_i,
    input  logic [LINE_W*N_DEV-1:0] route_i,
    input  logic [N_INT-1:0]        int_irq_i,
    output logic                    host_irq_o,
    output logic [N_LINE-1:0]       line_irq_o
);
    logic [N_DEV-1:0] armed;
    assign armed = status_i & mask_i;

    for (genvar k = 0; k < N_LINE; k++) begin : g_line
        logic [N_DEV-1:0] hit;
        for (genvar i = 0; i < N_DEV; i++) begin : g_dev
            assign hit[i] = armed[i] && (route_i[LINE_W*i +: LINE_W] == LINE_W'(k));
        end
        assign line_irq_o[k] = steer_en_i && (|hit);
    end

    assign host_irq_o = (|int_irq_i) || (!steer_en_i && (|armed));

    // R6: in steering mode, device status never reaches the host line
    assert_host_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_en_i && (int_irq_i == '0)) |-> !host_irq_o);
endmodule

// File: rtl/sirq_status_ctrl.sv
module sirq_status_ctrl
    import sirq_pkg::*;
#(
    parameter int unsigned N_DEV = 8,
    parameter int unsigned N_INT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_DEV-1:0]        dev_irq_i,
    input  logic [N_INT-1:0]        int_irq_i,
    input  logic                    mode_steer_i,
    input  logic [N_DEV-1:0]        irq_mask_i,
    input  logic [LINE_W*N_DEV-1:0] route_map_i,
    input  logic                    clr_valid_i,
    input  logic [N_DEV-1:0]        clr_bits_i,
    input  logic                    eoi_valid_i,
    input  logic [LINE_W-1:0]       eoi_line_i,
    output logic [N_DEV-1:0]        status_o,
    output logic                    host_irq_o,
    output logic [N_LINE-1:0]       line_irq_o
);
    sirq_mode_e state_q, state_d;
    logic       steer_en;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_AGGR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_AGGR:  if (mode_steer_i)  state_d = MODE_STEER;
            MODE_STEER: if (!mode_steer_i) state_d = MODE_AGGR;
            default:    state_d = MODE_AGGR;
        endcase
    end

    always_comb begin
        steer_en = (state_q == MODE_STEER);
    end

    logic [N_DEV-1:0] lvl_q;
    logic [N_DEV-1:0] eoi_hit;

    for (genvar i = 0; i < N_DEV; i++) begin : g_eoi
        assign eoi_hit[i] = steer_en && eoi_valid_i &&
                            (route_map_i[LINE_W*i +: LINE_W] == eoi_line_i);
    end

    sirq_level_copy #(.N_DEV(N_DEV)) u_lvl (
        .clk(clk), .rst_n(rst_n), .dev_irq_i(dev_irq_i), .lvl_q_o(lvl_q)
    );

    sirq_status_bank #(.N_DEV(N_DEV)) u_bank (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_q),
        .clr_valid_i(clr_valid_i), .clr_bits_i(clr_bits_i),
        .eoi_hit_i(eoi_hit), .status_o(status_o)
    );

    sirq_line_router #(.N_DEV(N_DEV), .N_INT(N_INT)) u_route (
        .clk(clk), .rst_n(rst_n), .steer_en_i(steer_en),
        .status_i(status_o), .mask_i(irq_mask_i), .route_i(route_map_i),
        .int_irq_i(int_irq_i), .host_irq_o(host_irq_o), .line_irq_o(line_irq_o)
    );

    // R9: an EOI in single-line mode (without a clear) drops no status bit
    assert_eoi_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_AGGR && eoi_valid_i && !clr_valid_i)
        |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R5: the steered lines stay quiet while single-line mode is active
    assert_lines_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_AGGR) |-> (line_irq_o == '0));
endmodule

// File: tb/sirq_status_ctrl_tb.sv
module sirq_status_ctrl_tb_top;
    localparam int N_DEV = 8;
    localparam int N_INT = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_DEV-1:0] dev_irq = '0;
    logic [N_INT-1:0] int_irq = '0;
    logic             mode_steer = 1'b0;
    logic [N_DEV-1:0] mask = '1;
    logic [2*N_DEV-1:0] route;
    logic             clr_valid = 1'b0;
    logic [N_DEV-1:0] clr_bits = '0;
    logic             eoi_valid = 1'b0;
    logic [1:0]       eoi_line = '0;
    logic [N_DEV-1:0] status;
    logic             host_irq;
    logic [3:0]       line_irq;

    int vectors = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // device i routes to line i%4: dev0->0, dev1->1, dev5->1
    initial begin
        for (int i = 0; i < N_DEV; i++) route[2*i +: 2] = 2'(i % 4);
    end

    sirq_status_ctrl #(.N_DEV(N_DEV), .N_INT(N_INT)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_irq_i(dev_irq), .int_irq_i(int_irq),
        .mode_steer_i(mode_steer), .irq_mask_i(mask), .route_map_i(route),
        .clr_valid_i(clr_valid), .clr_bits_i(clr_bits),
        .eoi_valid_i(eoi_valid), .eoi_line_i(eoi_line),
        .status_o(status), .host_irq_o(host_irq), .line_irq_o(line_irq)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_clear(logic [N_DEV-1:0] b);
        clr_valid = 1'b1; clr_bits = b;
        tick(1);
        clr_valid = 1'b0; clr_bits = '0;
    endtask

    task automatic do_eoi(logic [1:0] l);
        eoi_valid = 1'b1; eoi_line = l;
        tick(1);
        eoi_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(1);
        chk("R1", "status", 32'(status), 0);
        chk("R1", "host", 32'(host_irq), 0);
        chk("R1", "lines", 32'(line_irq), 0);
    endtask

    task automatic t_latch;
        dev_irq = 8'h05; tick(2);
        chk("R2", "status after two edges", 32'(status), 32'h05);
        dev_irq = 8'h00; tick(3);
        chk("R2", "status held", 32'(status), 32'h05);
        chk("R5", "host from status", 32'(host_irq), 1);
        chk("R5", "lines quiet", 32'(line_irq), 0);
    endtask

    task automatic t_w1c;
        do_clear(8'h01);
        chk("R3", "status after clear", 32'(status), 32'h04);
        do_clear(8'h04);
        chk("R3", "status empty", 32'(status), 0);
        chk("R5", "host low", 32'(host_irq), 0);
    endtask

    task automatic t_blocked;
        dev_irq = 8'h02; tick(3);
        do_clear(8'h02);
        chk("R4", "blocked clear", 32'(status), 32'h02);
        dev_irq = 8'h00; tick(3);
        chk("R4", "still latched", 32'(status), 32'h02);
        do_clear(8'h02);
        chk("R3", "clear after drop", 32'(status), 0);
    endtask

    task automatic t_aggr_int;
        int_irq = 2'b01; tick(1);
        chk("R5", "host from internal", 32'(host_irq), 1);
        int_irq = 2'b00; tick(1);
    endtask

    task automatic t_steer;
        mode_steer = 1'b1; dev_irq = 8'h20; tick(3);
        chk("R6", "status", 32'(status), 32'h20);
        chk("R6", "dev5 on line1", 32'(line_irq), 32'h2);
        chk("R6", "host isolated", 32'(host_irq), 0);
        int_irq = 2'b10; tick(1);
        chk("R6", "host internal", 32'(host_irq), 1);
        int_irq = 2'b00;
        mask = 8'hDF; tick(1);
        chk("R7", "masked line", 32'(line_irq), 0);
        chk("R7", "status visible", 32'(status), 32'h20);
        mask = 8'hFF; tick(1);
    endtask

    task automatic t_eoi;
        dev_irq = 8'h23; tick(3);
        dev_irq = 8'h02; tick(3);
        chk("R8", "pre eoi", 32'(status), 32'h23);
        chk("R6", "lines 0,1", 32'(line_irq), 32'h3);
        do_eoi(2'd1);
        chk("R8", "eoi line1", 32'(status), 32'h03);
        dev_irq = 8'h00; tick(3);
        do_eoi(2'd1);
        chk("R8", "eoi line1 again", 32'(status), 32'h01);
        do_eoi(2'd0);
        chk("R8", "eoi line0", 32'(status), 0);
    endtask

    task automatic t_eoi_aggr;
        mode_steer = 1'b0; tick(2);
        dev_irq = 8'h01; tick(3); dev_irq = 8'h00; tick(3);
        do_eoi(2'd0);
        chk("R9", "eoi ignored", 32'(status), 32'h01);
        chk("R5", "lines quiet", 32'(line_irq), 0);
    endtask

    task automatic t_switch;
        mode_steer = 1'b1;
        #1;
        chk("R10", "host before edge", 32'(host_irq), 1);
        tick(1);
        chk("R10", "host after edge", 32'(host_irq), 0);
        chk("R10", "line0 after edge", 32'(line_irq), 32'h1);
        mode_steer = 1'b0; tick(1);
        do_clear(8'h01);
        chk("R3", "final clear", 32'(status), 0);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_latch();
        t_w1c();
        t_blocked();
        t_aggr_int();
        t_steer();
        t_eoi();
        t_eoi_aggr();
        t_switch();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule